// File: doc/BRIEF.md
# Multi-Function 4-Bit Execution Unit

This block is the arithmetic core of a small processor datapath. It takes two 4-bit operands and a 3-bit operation code, and in the same cycle it returns a 4-bit result with a zero flag and a signed-overflow flag. It can do signed addition, signed subtraction, a multiply of the two low 2-bit fields, a one-bit shift left or right, and a signed maximum or minimum.

The unit is purely combinational. It holds no registers and no sequencing state. The surrounding processor reads the operands from its register file, presents them together with the operation code, and writes the result back on its own clock. Because the outputs follow the inputs directly, there is no handshake and no back-pressure. The caller samples the outputs once the inputs have settled.

Addition and subtraction share one ripple adder. For subtraction, operand B is inverted and the carry-in is forced high. The multiplier, the shifters and the signed comparator sit beside the adder, and a single selector chooses among their outputs.

Top module: `exu_core`

## Requirements
- R1: With `op_sel` = 0 (add), `result` is A + B modulo 16, and `ovf_flag` is 1 exactly when A and B have the same sign bit and the sign bit of `result` differs from it.
- R2: With `op_sel` = 1 (subtract), `result` is A − B modulo 16. `ovf_flag` is 1 exactly when the true signed difference lies outside −8..7.
- R3: With `op_sel` = 2 (multiply), `result` is the unsigned product of A[1:0] and B[1:0] as a full 4-bit value. The upper two bits of A and B have no effect.
- R4: With `op_sel` = 3 (shift left), `result` is A shifted one place toward bit 3, with bit 0 cleared. B has no effect.
- R5: With `op_sel` = 4 (shift right), `result` is A shifted one place toward bit 0, with bit 3 cleared (logical shift). B has no effect.
- R6: With `op_sel` = 5 (maximum), `result` is whichever of A and B is larger as a signed two's-complement value.
- R7: With `op_sel` = 6 (minimum), `result` is whichever of A and B is smaller as a signed value. When A equals B, the result of both maximum and minimum is that common value.
- R8: `ovf_flag` is 0 for every `op_sel` other than 0 and 1.
- R9: `zero_flag` is 1 exactly when `result` is 0000, for every operation.
- R10: `op_sel` = 7 is reserved. It gives `result` 0000, `zero_flag` 1 and `ovf_flag` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code: 0 add, 1 sub, 2 mul, 3 shl, 4 shr, 5 max, 6 min, 7 reserved |
| opnd_a | input | 4 | First operand (A) |
| opnd_b | input | 4 | Second operand (B) |
| result | output | 4 | Result of the selected operation |
| zero_flag | output | 1 | High when result is zero |
| ovf_flag | output | 1 | Signed overflow of add/sub |

## Verification
The bound checker checks the following properties whenever an input changes:
- the add and subtract results against a plain arithmetic reference;
- the bounds of the multiply result;
- the cleared bit after each shift;
- the ordering relations that maximum and minimum must satisfy;
- the zero flag;
- that overflow stays low outside add and subtract;
- the cleared outputs of the reserved code.

These properties cannot show two things: the exact overflow boundary values, and that B or the upper operand bits really have no effect. Only the bench shows these. It uses a table of hand-worked corner vectors and an exhaustive sweep of every operand pair under every operation code.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int EXU_DATA_W = 4;
  localparam int EXU_OP_W   = 3;

  typedef enum logic [EXU_OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_SHL = 3'd3,
    OP_SHR = 3'd4,
    OP_MAX = 3'd5,
    OP_MIN = 3'd6,
    OP_RSV = 3'd7
  } exu_op_e;

endpackage

// File: rtl/exu_addsub.sv
module exu_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);

  logic [W:0]   carry;
  logic [W-1:0] b_eff;

  assign carry[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign b_eff[i]   = b[i] ^ sub;
    assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
  end

  // same-signed inputs to the adder giving a result of the other sign
  assign ovf = (a[W-1] ~^ b_eff[W-1]) & (sum[W-1] ^ a[W-1]);

endmodule

// File: rtl/exu_mult.sv
module exu_mult #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod
);

  localparam int H = W / 2;

  logic [H-1:0] fa;
  logic [H-1:0] fb;
  logic [W-1:0] pp [H];

  assign fa = a[H-1:0];
  assign fb = b[H-1:0];

  for (genvar i = 0; i < H; i++) begin : g_pp
    assign pp[i] = fb[i] ? (W'(fa) << i) : '0;
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < H; i++) prod = prod + pp[i];
  end

endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] shl,
  output logic [W-1:0] shr
);

  assign shl = {a[W-2:0], 1'b0};
  assign shr = {1'b0, a[W-1:1]};

endmodule

// File: rtl/exu_minmax.sv
module exu_minmax #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] vmax,
  output logic [W-1:0] vmin
);

  logic a_lt_b;

  assign a_lt_b = $signed(a) < $signed(b);
  assign vmax   = a_lt_b ? b : a;
  assign vmin   = a_lt_b ? a : b;

endmodule

// File: rtl/exu_core.sv
module exu_core #(
  parameter int DATA_W = exu_pkg::EXU_DATA_W
) (
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              zero_flag,
  output logic              ovf_flag
);
  import exu_pkg::*;

  exu_op_e           op;
  logic              is_sub;
  logic [DATA_W-1:0] as_sum, mul_p, sh_l, sh_r, mx, mn;
  logic              as_ovf;

  assign op     = exu_op_e'(op_sel);
  assign is_sub = (op == OP_SUB);

  exu_addsub #(.W(DATA_W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(is_sub), .sum(as_sum), .ovf(as_ovf)
  );

  exu_mult #(.W(DATA_W)) u_mult (
    .a(opnd_a), .b(opnd_b), .prod(mul_p)
  );

  exu_shift #(.W(DATA_W)) u_shift (
    .a(opnd_a), .shl(sh_l), .shr(sh_r)
  );

  exu_minmax #(.W(DATA_W)) u_minmax (
    .a(opnd_a), .b(opnd_b), .vmax(mx), .vmin(mn)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result = as_sum;
      OP_MUL:         result = mul_p;
      OP_SHL:         result = sh_l;
      OP_SHR:         result = sh_r;
      OP_MAX:         result = mx;
      OP_MIN:         result = mn;
      default:        result = '0;
    endcase
  end

  assign zero_flag = ~|result;
  assign ovf_flag  = ((op == OP_ADD) | (op == OP_SUB)) & as_ovf;

endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk #(
  parameter int DATA_W = 4
) (
  input logic [2:0]        op,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic [DATA_W-1:0] result,
  input logic              zero,
  input logic              ovf
);
  localparam int H = DATA_W / 2;
  localparam int MUL_MAX = ((1 << H) - 1) * ((1 << H) - 1);

  logic [DATA_W-1:0] ref_add, ref_sub;

  always_comb begin
    ref_add = a + b;
    ref_sub = a - b;
    if (op == 3'd0) begin
      AST_ADD_SUM: assert (result == ref_add); // R1
    end
    if (op == 3'd1) begin
      AST_SUB_DIFF: assert (result == ref_sub); // R2
    end
    if (op == 3'd2) begin
      AST_MUL_BOUND: assert (int'(result) <= MUL_MAX); // R3
    end
    if (op == 3'd3) begin
      AST_SHL_LSB_CLEAR: assert (result[0] == 1'b0); // R4
    end
    if (op == 3'd4) begin
      AST_SHR_MSB_CLEAR: assert (result[DATA_W-1] == 1'b0); // R5
    end
    if (op == 3'd5) begin
      AST_MAX_ORDER: assert ($signed(result) >= $signed(a) && $signed(result) >= $signed(b) && (result == a || result == b)); // R6
    end
    if (op == 3'd6) begin
      AST_MIN_ORDER: assert ($signed(result) <= $signed(a) && $signed(result) <= $signed(b) && (result == a || result == b)); // R7
    end
    if (op > 3'd1) begin
      AST_NO_OVERFLOW: assert (!ovf); // R8
    end
    AST_ZERO_FLAG: assert (zero == (result == '0)); // R9
    if (op == 3'd7) begin
      AST_RSV_CLEAR: assert (result == '0 && zero && !ovf); // R10
    end
  end

endmodule

bind exu_core exu_core_chk #(.DATA_W(DATA_W)) u_exu_core_chk (
  .op(op_sel), .a(opnd_a), .b(opnd_b),
  .result(result), .zero(zero_flag), .ovf(ovf_flag)
);

// File: tb/tb_exu_core.sv
module tb_exu_core;

  logic       clk = 1'b0;
  logic [2:0] op_sel;
  logic [3:0] opnd_a, opnd_b;
  logic [3:0] result;
  logic       zero_flag, ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  exu_core dut (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
  );

  // {op, a, b, result, zero, ovf}
  localparam int NV = 21;
  localparam logic [16:0] VEC [NV] = '{
    {3'd0, 4'h3, 4'h4, 4'h7, 1'b0, 1'b0},
    {3'd0, 4'h7, 4'h1, 4'h8, 1'b0, 1'b1},
    {3'd0, 4'h8, 4'h8, 4'h0, 1'b1, 1'b1},
    {3'd0, 4'hF, 4'h1, 4'h0, 1'b1, 1'b0},
    {3'd1, 4'h5, 4'h3, 4'h2, 1'b0, 1'b0},
    {3'd1, 4'h8, 4'h1, 4'h7, 1'b0, 1'b1},
    {3'd1, 4'h7, 4'hF, 4'h8, 1'b0, 1'b1},
    {3'd1, 4'h4, 4'h4, 4'h0, 1'b1, 1'b0},
    {3'd2, 4'h3, 4'h3, 4'h9, 1'b0, 1'b0},
    {3'd2, 4'hE, 4'h7, 4'h6, 1'b0, 1'b0},
    {3'd2, 4'h4, 4'hB, 4'h0, 1'b1, 1'b0},
    {3'd3, 4'h9, 4'hF, 4'h2, 1'b0, 1'b0},
    {3'd3, 4'h8, 4'h0, 4'h0, 1'b1, 1'b0},
    {3'd4, 4'h9, 4'hF, 4'h4, 1'b0, 1'b0},
    {3'd4, 4'h1, 4'h0, 4'h0, 1'b1, 1'b0},
    {3'd5, 4'h3, 4'hF, 4'h3, 1'b0, 1'b0},
    {3'd5, 4'h8, 4'h7, 4'h7, 1'b0, 1'b0},
    {3'd6, 4'h3, 4'hF, 4'hF, 1'b0, 1'b0},
    {3'd6, 4'h8, 4'h7, 4'h8, 1'b0, 1'b0},
    {3'd5, 4'h6, 4'h6, 4'h6, 1'b0, 1'b0},
    {3'd7, 4'h5, 4'h5, 4'h0, 1'b1, 1'b0}
  };

  function automatic string op_tag(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R10";
    endcase
  endfunction

  // independent reference model: returns {result, zero, ovf}
  function automatic logic [5:0] model(int op, int a, int b);
    int sa, sb, t, r;
    bit v;
    sa = (a >= 8) ? a - 16 : a;
    sb = (b >= 8) ? b - 16 : b;
    v = 1'b0;
    case (op)
      0: begin t = sa + sb; r = t & 15; v = (t > 7) || (t < -8); end
      1: begin t = sa - sb; r = t & 15; v = (t > 7) || (t < -8); end
      2: r = (a % 4) * (b % 4);
      3: r = (a * 2) & 15;
      4: r = a / 2;
      5: r = (sa >= sb) ? a : b;
      6: r = (sa <= sb) ? a : b;
      default: r = 0;
    endcase
    return {4'(r), (r == 0), v};
  endfunction

  task automatic apply(input int op, input int a, input int b);
    @(negedge clk);
    op_sel = 3'(op);
    opnd_a = 4'(a);
    opnd_b = 4'(b);
    @(posedge clk);
    #1;
  endtask

  task automatic check_out(input int op, input logic [3:0] er, input logic ez, input logic ev);
    string ot;
    ot = (op < 2) ? op_tag(op) : "R8";
    checks++;
    if (result !== er) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h", op_tag(op), op, opnd_a, opnd_b, result, er);
    end
    checks++;
    if (zero_flag !== ez) begin
      errors++;
      $display("FAIL R9 op=%0d a=%h b=%h zero actual=%b expected=%b", op, opnd_a, opnd_b, zero_flag, ez);
    end
    checks++;
    if (ovf_flag !== ev) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h ovf actual=%b expected=%b", ot, op, opnd_a, opnd_b, ovf_flag, ev);
    end
  endtask

  initial begin
    op_sel = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    #1;
    // initial state: add of zeros gives zero result (R9)
    check_out(0, 4'h0, 1'b1, 1'b0);

    // table of hand-worked corner vectors
    for (int i = 0; i < NV; i++) begin
      apply(int'(VEC[i][16:14]), int'(VEC[i][13:10]), int'(VEC[i][9:6]));
      check_out(int'(VEC[i][16:14]), VEC[i][5:2], VEC[i][1], VEC[i][0]);
    end

    // directed: exhaustive sweep; B / upper bits ignored for R3 R4 R5, ties for R7
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [5:0] e;
          e = model(op, a, b);
          apply(op, a, b);
          check_out(op, e[5:2], e[1], e[0]);
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule